// File: doc/BRIEF.md
# Serial TDM Frame Receiver

This block is the controller-side receive path for a 256-bit time-division multiplexed serial frame. The frame starts with a 16-bit tag slot and continues with twelve 20-bit data slots. The controller generates its own frame sync pulse and feeds it to this block alongside the serial input bit stream. From these two signals the receiver finds the frame boundaries. It then decodes the tag slot into a peer-ready flag and twelve per-slot valid flags, and gathers each data slot into a 20-bit parallel word. It also picks out the interrupt flag carried in the last bit of the frame.

When a complete frame has been received, the receiver updates its outputs together and raises a one-cycle strobe, so that everything read in that cycle belongs to the same frame. A slot is published only when its valid flag in that frame is set. Slots 1 and 2 carry the peer's status address and status data; the block passes them on like any other slot and does not interpret them. A non-zero value in the reserved tag bits sets a sticky framing-error flag.

Top module: `tdm_frame_rx`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: A sync rise is `frame_sync_i` high in a cycle after a cycle with it low. The `ser_din_i` bit sampled with a sync rise is frame position F255, and the next sample is F0. Frame positions run from F0 to F255. Slot 0 covers F0..F15. Data slot k (1..12) covers F(16+20(k-1)) through F(35+20(k-1)), most significant bit first. The last bit of slot 12 is F255.
- R3: `frame_done_o` is high for exactly one cycle after the edge on which a sync rise is sampled at F255 of an aligned frame. The first sync rise after reset, and a sync rise at any other position, realign the frame without a strobe.
- R4: From the strobe onward, `peer_ready_o` equals F0, and `slot_valid_o[k-1]` equals F(k) of the frame just completed.
- R5: From the strobe onward, `irq_o` equals the F255 bit of that frame.
- R6: When slot k was marked valid, `slot_data_o[(k-1)*20 +: 20]` holds that slot's 20 bits from the strobe onward, with bit 19 being the first bit received.
- R7: When slot k was marked invalid, its field in `slot_data_o` keeps its previous value across the strobe.
- R8: `peer_ready_o`, `slot_valid_o`, `irq_o` and `slot_data_o` change only in strobe cycles.
- R9: A 1 received at F13, F14 or F15 of an aligned frame sets `tag_err_o` on the next edge. The flag then stays 1 until reset.
- R10: Bits received before the first sync rise after reset never set `tag_err_o` and never produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; its rising edge is the bit clock's falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_sync_i | input | 1 | Frame sync generated by the controller |
| ser_din_i | input | 1 | Serial input data from the peer |
| frame_done_o | output | 1 | One-cycle strobe when a frame has been published |
| peer_ready_o | output | 1 | Peer-ready flag of the last complete frame |
| slot_valid_o | output | NUM_SLOTS | Valid flags of slots 1..12 of the last complete frame |
| irq_o | output | 1 | Interrupt flag from the last bit of the last complete frame |
| tag_err_o | output | 1 | Sticky flag for a non-zero reserved tag bit |
| slot_data_o | output | NUM_SLOTS*SLOT_W | Published slot words, slot 1 in the low 20 bits |

## Verification
The frame sequence starts with an all-valid frame with distinct data in every slot, which exposes any slot swap, bit reversal or off-by-one slot boundary. A sparse valid mask and then an all-invalid frame follow; these separate correct gating from unconditional publication. A frame cut short by an early sync checks that a misplaced sync realigns the receiver without publishing anything. Junk data with ones before the first sync, and then a single reserved bit set in a later frame, show that the error flag depends on alignment and is sticky.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Frame position of the last bit of data slot k (k counted from zero).
  function automatic int unsigned slot_last_pos(int unsigned k,
                                                int unsigned tag_w,
                                                int unsigned slot_w);
    return tag_w + (k + 1) * slot_w - 1;
  endfunction

  // Total number of bit positions in one frame.
  function automatic int unsigned frame_bits(int unsigned tag_w,
                                             int unsigned slot_w,
                                             int unsigned num_slots);
    return tag_w + num_slots * slot_w;
  endfunction

endpackage

// File: rtl/tdm_rx_framer.sv
// Tracks frame position from the controller's sync and qualifies each sample.
module tdm_rx_framer #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             bit_en_o,
  output logic             frame_end_o
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic             sync_q;
  logic             aligned_q, aligned_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             sync_rise;
  logic             at_last;

  assign sync_rise = frame_sync_i & ~sync_q;
  assign at_last   = (pos_q == LAST_POS);

  always_comb begin
    pos_d     = pos_q;
    aligned_d = aligned_q;
    if (sync_rise) begin
      pos_d     = '0;
      aligned_d = 1'b1;
    end else if (aligned_q && !at_last) begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      aligned_q <= 1'b0;
      pos_q     <= '0;
    end else begin
      sync_q    <= frame_sync_i;
      aligned_q <= aligned_d;
      pos_q     <= pos_d;
    end
  end

  // A sample belongs to the current frame unless a sync rise lands early.
  assign bit_en_o    = aligned_q & (~sync_rise | at_last);
  assign frame_end_o = aligned_q & sync_rise & at_last;
  assign pos_o       = pos_q;

endmodule

// File: rtl/tdm_rx_tag.sv
// Captures the tag slot flags and watches the reserved tag bits.
module tdm_rx_tag #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din_i,
  input  logic [CNT_W-1:0]     pos_i,
  input  logic                 bit_en_i,
  output logic                 ready_o,
  output logic [NUM_SLOTS-1:0] valid_o,
  output logic                 err_o
);

  localparam int unsigned      FLAG_N  = NUM_SLOTS + 1;
  localparam int unsigned      IDX_W   = $clog2(FLAG_N);
  localparam logic [CNT_W-1:0] FLAG_END = CNT_W'(FLAG_N);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W);

  logic [FLAG_N-1:0] flags_q, flags_d;
  logic              err_q, err_d;
  logic              in_flags;
  logic              in_rsvd;

  assign in_flags = bit_en_i & (pos_i < FLAG_END);
  assign in_rsvd  = bit_en_i & (pos_i >= FLAG_END) & (pos_i < TAG_END);

  always_comb begin
    flags_d = flags_q;
    err_d   = err_q;
    if (in_flags) begin
      flags_d[pos_i[IDX_W-1:0]] = din_i;
    end
    if (in_rsvd && din_i) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      err_q   <= err_d;
    end
  end

  assign ready_o = flags_q[0];
  assign valid_o = flags_q[FLAG_N-1:1];
  assign err_o   = err_q;

endmodule

// File: rtl/tdm_rx_slots.sv
// Deserialises the data slots into one staging word per slot.
module tdm_rx_slots #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        din_i,
  input  logic [CNT_W-1:0]            pos_i,
  input  logic                        bit_en_i,
  output logic [NUM_SLOTS*SLOT_W-1:0] stage_next_o
);

  logic [SLOT_W-1:0] shift_q, shift_d;
  logic [SLOT_W-1:0] word;

  assign word = {shift_q[SLOT_W-2:0], din_i};

  always_comb begin
    shift_d = shift_q;
    if (bit_en_i) begin
      shift_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [CNT_W-1:0] END_POS =
      CNT_W'(tdm_rx_pkg::slot_last_pos(k, TAG_W, SLOT_W));

    logic [SLOT_W-1:0] stage_q, stage_d;
    logic              slot_end;

    assign slot_end = bit_en_i & (pos_i == END_POS);

    always_comb begin
      stage_d = stage_q;
      if (slot_end) begin
        stage_d = word;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else begin
        stage_q <= stage_d;
      end
    end

    // The next-state view lets the final slot publish on its own last bit.
    assign stage_next_o[k*SLOT_W +: SLOT_W] = stage_d;
  end

endmodule

// File: rtl/tdm_frame_rx.sv
// Serial TDM frame receiver: framing, tag decode, slot capture, publication.
module tdm_frame_rx #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_sync_i,
  input  logic                        ser_din_i,
  output logic                        frame_done_o,
  output logic                        peer_ready_o,
  output logic [NUM_SLOTS-1:0]        slot_valid_o,
  output logic                        irq_o,
  output logic                        tag_err_o,
  output logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o
);

  localparam int unsigned FRAME_LEN = tdm_rx_pkg::frame_bits(TAG_W, SLOT_W, NUM_SLOTS);
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

  logic [CNT_W-1:0]            pos;
  logic                        bit_en;
  logic                        frame_end;
  logic                        tag_ready;
  logic [NUM_SLOTS-1:0]        tag_valid;
  logic [NUM_SLOTS*SLOT_W-1:0] stage_next;

  tdm_rx_framer #(
    .FRAME_LEN (FRAME_LEN),
    .CNT_W     (CNT_W)
  ) framer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync_i (frame_sync_i),
    .pos_o        (pos),
    .bit_en_o     (bit_en),
    .frame_end_o  (frame_end)
  );

  tdm_rx_tag #(
    .TAG_W     (TAG_W),
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W)
  ) tag_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .din_i    (ser_din_i),
    .pos_i    (pos),
    .bit_en_i (bit_en),
    .ready_o  (tag_ready),
    .valid_o  (tag_valid),
    .err_o    (tag_err_o)
  );

  tdm_rx_slots #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W)
  ) slots_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .din_i        (ser_din_i),
    .pos_i        (pos),
    .bit_en_i     (bit_en),
    .stage_next_o (stage_next)
  );

  // Publication registers, all loaded on the frame-end edge.
  logic                 done_q, done_d;
  logic                 ready_q, ready_d;
  logic [NUM_SLOTS-1:0] valid_q, valid_d;
  logic                 irq_q, irq_d;

  always_comb begin
    done_d  = frame_end;
    ready_d = ready_q;
    valid_d = valid_q;
    irq_d   = irq_q;
    if (frame_end) begin
      ready_d = tag_ready;
      valid_d = tag_valid;
      irq_d   = ser_din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ready_q <= 1'b0;
      valid_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      done_q  <= done_d;
      ready_q <= ready_d;
      valid_q <= valid_d;
      irq_q   <= irq_d;
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pub
    logic [SLOT_W-1:0] pub_q, pub_d;
    logic              load;

    assign load = frame_end & tag_valid[k];

    always_comb begin
      pub_d = pub_q;
      if (load) begin
        pub_d = stage_next[k*SLOT_W +: SLOT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pub_q <= '0;
      end else begin
        pub_q <= pub_d;
      end
    end

    assign slot_data_o[k*SLOT_W +: SLOT_W] = pub_q;
  end

  assign frame_done_o = done_q;
  assign peer_ready_o = ready_q;
  assign slot_valid_o = valid_q;
  assign irq_o        = irq_q;

endmodule

// File: rtl/tdm_frame_rx_chk.sv
// Port-level properties for tdm_frame_rx, attached by bind.
module tdm_frame_rx_chk #(
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        frame_sync_i,
  input logic                        ser_din_i,
  input logic                        frame_done_o,
  input logic                        peer_ready_o,
  input logic [NUM_SLOTS-1:0]        slot_valid_o,
  input logic                        irq_o,
  input logic                        tag_err_o,
  input logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o
);

  // R1: outputs are cleared while reset is held.
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!frame_done_o && !tag_err_o && !irq_o);
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  assert_done_follows_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> $past(frame_sync_i));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err_o |=> tag_err_o);

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |-> ($stable(slot_valid_o) && $stable(peer_ready_o) && $stable(irq_o)));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |-> $stable(slot_data_o));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_keep
    assert_invalid_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_o && !slot_valid_o[k]) |-> $stable(slot_data_o[k*SLOT_W +: SLOT_W]));
  end

  // Input data is not referenced by any property.
  logic unused_din;
  assign unused_din = ser_din_i;

endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(
  .SLOT_W    (SLOT_W),
  .NUM_SLOTS (NUM_SLOTS)
) chk_i (.*);

// File: tb/tdm_frame_rx_tb_top.sv
module tdm_frame_rx_tb_top;

  localparam int NS = 12;
  localparam int SW = 20;
  localparam int TW = 16;
  localparam int FL = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_sync;
  logic ser_din;

  logic               done_o, ready_o, irq_o, err_o;
  logic [NS-1:0]      valid_o;
  logic [NS*SW-1:0]   data_o;

  always #5 clk = ~clk;

  tdm_frame_rx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync_i (frame_sync),
    .ser_din_i    (ser_din),
    .frame_done_o (done_o),
    .peer_ready_o (ready_o),
    .slot_valid_o (valid_o),
    .irq_o        (irq_o),
    .tag_err_o    (err_o),
    .slot_data_o  (data_o)
  );

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  bit finished = 0;

  // ---------------- behavioural reference model ----------------
  bit              model_live = 0;
  bit              m_aligned, m_sync_prev;
  int              m_pos;
  bit              m_bits[FL];
  logic            exp_done, exp_ready, exp_irq, exp_err;
  logic [NS-1:0]   exp_valid;
  logic [SW-1:0]   exp_data[NS];

  always @(posedge clk) begin
    model_live <= 1'b1;
    if (!rst_n) begin
      m_aligned = 0; m_sync_prev = 0; m_pos = 0;
      exp_done = 0; exp_ready = 0; exp_irq = 0; exp_err = 0; exp_valid = '0;
      for (int k = 0; k < NS; k++) exp_data[k] = '0;
    end else begin
      exp_done = 0;
      if (frame_sync && !m_sync_prev) begin
        if (m_aligned && m_pos == FL - 1) begin
          m_bits[FL-1] = ser_din;
          exp_done  = 1;
          exp_ready = m_bits[0];
          exp_irq   = ser_din;
          for (int k = 0; k < NS; k++) begin
            exp_valid[k] = m_bits[k+1];
            if (m_bits[k+1]) begin
              for (int b = 0; b < SW; b++) exp_data[k][SW-1-b] = m_bits[TW + SW*k + b];
            end
          end
        end
        m_aligned = 1;
        m_pos = 0;
      end else if (m_aligned) begin
        m_bits[m_pos] = ser_din;
        if (m_pos >= NS + 1 && m_pos < TW && ser_din) exp_err = 1;
        if (m_pos < FL - 1) m_pos++;
      end
      m_sync_prev = frame_sync;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (model_live && !finished) begin
      if (!rst_n) begin
        check(done_o === 1'b0 && ready_o === 1'b0 && irq_o === 1'b0 && err_o === 1'b0,
              "R1 flags in reset", SW'({done_o, ready_o, irq_o, err_o}), '0);
        check(valid_o === '0, "R1 valid in reset", SW'(valid_o), '0);
        check(data_o === '0, "R1 data in reset", data_o[SW-1:0], '0);
      end else begin
        if (done_o === 1'b1) done_seen++;
        check(done_o === exp_done, "R3 R10 frame strobe", SW'(done_o), SW'(exp_done));
        check(ready_o === exp_ready, "R4 R8 peer ready", SW'(ready_o), SW'(exp_ready));
        check(valid_o === exp_valid, "R4 R8 slot valid flags", SW'(valid_o), SW'(exp_valid));
        check(irq_o === exp_irq, "R5 R8 interrupt flag", SW'(irq_o), SW'(exp_irq));
        check(err_o === exp_err, "R9 R10 tag error", SW'(err_o), SW'(exp_err));
        for (int k = 0; k < NS; k++) begin
          check(data_o[k*SW +: SW] === exp_data[k],
                exp_valid[k] ? $sformatf("R2 R6 R8 slot %0d", k + 1)
                             : $sformatf("R7 R8 slot %0d", k + 1),
                data_o[k*SW +: SW], exp_data[k]);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  bit fr[FL];

  task automatic drive(input bit s, input bit d);
    @(negedge clk);
    frame_sync = s;
    ser_din    = d;
  endtask

  task automatic build(input bit ready, input bit [NS-1:0] vld, input bit [2:0] rsv,
                       input bit irq, input int seed);
    fr[0] = ready;
    for (int k = 0; k < NS; k++) fr[k+1] = vld[k];
    for (int r = 0; r < 3; r++) fr[NS+1+r] = rsv[r];
    for (int k = 0; k < NS; k++) begin
      int t;
      logic [SW-1:0] v;
      t = seed * 7919 + k * 104729 + 12345 + (seed << (k % 9));
      v = t[SW-1:0];
      for (int b = 0; b < SW; b++) fr[TW + SW*k + b] = v[SW-1-b];
    end
    fr[FL-1] = irq;
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) drive(i < 15, fr[i]);
  endtask

  task automatic send_frame();
    for (int i = 0; i < FL - 1; i++) drive(i < 15, fr[i]);
    drive(1'b1, fr[FL-1]);
  endtask

  initial begin
    rst_n = 1'b0; frame_sync = 1'b0; ser_din = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10: junk with ones before any sync, then first sync only aligns.
    for (int i = 0; i < 40; i++) drive(1'b0, i[0]);
    drive(1'b1, 1'b1);

    build(1'b1, 12'hFFF, 3'b000, 1'b1, 1);       send_frame();   // all slots valid
    build(1'b0, 12'b0101_1010_0110, 3'b000, 1'b0, 2); send_frame(); // sparse mask, R7
    build(1'b1, 12'h000, 3'b000, 1'b1, 3);       send_frame();   // nothing valid
    build(1'b1, 12'hFFF, 3'b000, 1'b0, 4);
    send_bits(100); drive(1'b1, 1'b1);                            // early sync, R3
    build(1'b1, 12'hFFF, 3'b000, 1'b0, 5);       send_frame();
    build(1'b0, 12'hF0F, 3'b010, 1'b1, 6);       send_frame();   // reserved bit, R9
    build(1'b1, 12'hFFF, 3'b000, 1'b0, 7);       send_frame();   // error stays
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0);
    @(negedge clk);

    check(done_seen == 6, "R3 strobe count", SW'(done_seen), SW'(6));
    check(err_o === 1'b1, "R9 sticky error at end", SW'(err_o), SW'(1));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired (R3) actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule